// File: doc/BRIEF.md
# Test-and-Test-and-Set Lock Acquirer with Exponential Backoff

This block sits beside one requester and obtains a lock word that lives in shared memory. When the client raises an acquire pulse, the engine repeatedly fetches the lock word with ordinary reads. Only when a read shows the word clear does it attempt an atomic test-and-set. If another requester wins the race, the engine waits for a delay that doubles (more generally, multiplies by a power-of-two factor) with each consecutive loss. The delay is capped at a configurable maximum so that a waiter never sleeps long after the word has been freed. It then returns to read polling.

A successful test-and-set raises `granted` until the client pulses release. On release the engine writes zero to the lock word with a plain store and goes back to idle. The memory side is a valid/ready request channel with opcode, address and write data, plus a response channel that returns the old value of the word for reads and test-and-sets. A response arrives at least one cycle after its request is accepted. Stores return no response.

Top module: `tts_lock_engine`

## Requirements
- R1: After reset `idle` is 1, `granted` is 0 and no memory request is presented; while `idle` is 1 no request is ever presented.
- R2: After an acquire pulse in idle, the engine issues read requests (opcode 2'b01) to `lock_addr`; while reads return a nonzero word it keeps issuing reads and never a test-and-set.
- R3: A test-and-set request (opcode 2'b10) is issued only directly after a read response whose data is zero.
- R4: A test-and-set response of zero makes `granted` 1 from the next cycle on, with `idle` 0, and the attempt is not repeated.
- R5: A nonzero test-and-set response starts a backoff. For the n-th consecutive loss (n from 1), the backoff lasts D = BASE_DELAY·2^(LOG2_FACTOR·(n−1)) cycles. The next read request is presented D+1 cycles after the cycle in which the losing response arrived.
- R6: The backoff D never exceeds MAX_DELAY; once the formula exceeds it, every further loss waits exactly MAX_DELAY cycles.
- R7: The loss count restarts at zero on a successful acquisition, so the first loss of a later acquisition waits BASE_DELAY cycles.
- R8: A release pulse while granted drops `granted` and presents one store request (opcode 2'b11) to `lock_addr` with write data 0; after it is accepted the engine is idle.
- R9: A presented request keeps `mem_req_valid` high and its opcode unchanged until `mem_req_ready` accepts it.
- R10: `granted` and `idle` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | 1 | Pulse in idle: start acquiring the lock |
| rel_req | input | 1 | Pulse while granted: release the lock |
| lock_addr | input | ADDR_W | Address of the lock word |
| granted | output | 1 | Lock is held by this requester |
| idle | output | 1 | Engine is idle and will accept an acquire |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory accepts the presented request |
| mem_req_op | output | 2 | 01 read, 10 test-and-set, 11 store |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Store data (always zero) |
| mem_rsp_valid | input | 1 | Response for a read or test-and-set |
| mem_rsp_data | input | DATA_W | Old value of the lock word |

## Verification
The hardest condition to reach from the ports is a lost test-and-set. A requester working alone never loses, because the read that precedes the atomic shows the word clear. The bench memory model therefore holds a count of pending "steals". Each steal makes the next test-and-set answer as though a rival had grabbed and already dropped the word. A chain of six steals walks the backoff through its doubling steps into the cap, and the spacing of each following read checks the delay. Polling under a held word is produced by setting the word and clearing it only after a known number of reads, and a toggling ready exercises request holding.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT_READ,
        ST_TAS,
        ST_BACKOFF,
        ST_HELD,
        ST_RELEASE
    } lock_state_e;

    typedef enum logic [1:0] {
        MOP_NONE  = 2'b00,
        MOP_READ  = 2'b01,
        MOP_TAS   = 2'b10,
        MOP_STORE = 2'b11
    } mem_op_e;

    typedef struct packed {
        logic    valid;
        mem_op_e op;
    } mem_cmd_t;

    // base * 2^(log2f*attempt), clipped to cap
    function automatic int unsigned backoff_cycles(
        input int unsigned base,
        input int unsigned log2f,
        input int unsigned attempt,
        input int unsigned cap
    );
        longint unsigned scaled;
        int unsigned     sh;
        sh = log2f * attempt;
        if (sh >= 32) return cap;
        scaled = 64'(base) << sh;
        if (scaled > 64'(cap)) return cap;
        return 32'(scaled);
    endfunction

endpackage

// File: rtl/spin_attempt_ctr.sv
module spin_attempt_ctr #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             incr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (incr && count != CNT_TOP) begin
            count <= count + 1'b1;
        end
    end

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> count == '0)
        else $error("loss count not restarted after win");

endmodule

// File: rtl/spin_backoff_timer.sv
module spin_backoff_timer #(
    parameter int unsigned BASE_DELAY  = 4,
    parameter int unsigned LOG2_FACTOR = 1,
    parameter int unsigned MAX_DELAY   = 64,
    parameter int unsigned CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] attempt,
    output logic             done
);
    import spinlock_pkg::*;

    localparam int unsigned DLY_W = $clog2(MAX_DELAY + 1);

    logic [DLY_W-1:0] remaining;
    logic [DLY_W-1:0] load_value;

    always_comb begin
        load_value = DLY_W'(backoff_cycles(BASE_DELAY, LOG2_FACTOR, 32'(attempt), MAX_DELAY));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_value;
        end else if (remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    assign done = (remaining == DLY_W'(1));

    p_load_capped_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> (remaining != '0) && (remaining <= DLY_W'(MAX_DELAY)))
        else $error("backoff load outside 1..MAX_DELAY");

endmodule

// File: rtl/spin_lock_fsm.sv
module spin_lock_fsm (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acq_req,
    input  logic                  rel_req,
    input  logic                  req_ready,
    input  logic                  rsp_valid,
    input  logic                  rsp_zero,
    input  logic                  timer_done,
    output spinlock_pkg::mem_cmd_t cmd,
    output logic                  tas_win,
    output logic                  tas_fail,
    output logic                  granted,
    output logic                  idle
);
    import spinlock_pkg::*;

    lock_state_e state, next_state;
    logic        tas_sent;

    always_comb begin
        next_state = state;
        cmd        = '{valid: 1'b0, op: MOP_NONE};
        tas_win    = 1'b0;
        tas_fail   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (acq_req) next_state = ST_READ;
            end
            ST_READ: begin
                cmd = '{valid: 1'b1, op: MOP_READ};
                if (req_ready) next_state = ST_WAIT_READ;
            end
            ST_WAIT_READ: begin
                if (rsp_valid) next_state = rsp_zero ? ST_TAS : ST_READ;
            end
            ST_TAS: begin
                if (!tas_sent) begin
                    cmd = '{valid: 1'b1, op: MOP_TAS};
                end else if (rsp_valid) begin
                    if (rsp_zero) begin
                        tas_win    = 1'b1;
                        next_state = ST_HELD;
                    end else begin
                        tas_fail   = 1'b1;
                        next_state = ST_BACKOFF;
                    end
                end
            end
            ST_BACKOFF: begin
                if (timer_done) next_state = ST_READ;
            end
            ST_HELD: begin
                if (rel_req) next_state = ST_RELEASE;
            end
            ST_RELEASE: begin
                cmd = '{valid: 1'b1, op: MOP_STORE};
                if (req_ready) next_state = ST_IDLE;
            end
            default: next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tas_sent <= 1'b0;
        end else begin
            state    <= next_state;
            tas_sent <= (state == ST_TAS) && (next_state == ST_TAS)
                        && (tas_sent || (cmd.valid && req_ready));
        end
    end

    assign granted = (state == ST_HELD);
    assign idle    = (state == ST_IDLE);

endmodule

// File: rtl/tts_lock_engine.sv
module tts_lock_engine #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned BASE_DELAY  = 4,
    parameter int unsigned LOG2_FACTOR = 1,
    parameter int unsigned MAX_DELAY   = 64,
    parameter int unsigned CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_req,
    input  logic              rel_req,
    input  logic [ADDR_W-1:0] lock_addr,
    output logic              granted,
    output logic              idle,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_op,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    import spinlock_pkg::*;

    mem_cmd_t         cmd;
    logic             tas_win, tas_fail, timer_done, rsp_zero;
    logic [CNT_W-1:0] losses;

    assign rsp_zero = (mem_rsp_data == '0);

    spin_lock_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .acq_req    (acq_req),
        .rel_req    (rel_req),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .rsp_zero   (rsp_zero),
        .timer_done (timer_done),
        .cmd        (cmd),
        .tas_win    (tas_win),
        .tas_fail   (tas_fail),
        .granted    (granted),
        .idle       (idle)
    );

    spin_attempt_ctr #(.CNT_W(CNT_W)) u_losses (
        .clk   (clk),
        .rst   (rst),
        .clear (tas_win),
        .incr  (tas_fail),
        .count (losses)
    );

    spin_backoff_timer #(
        .BASE_DELAY  (BASE_DELAY),
        .LOG2_FACTOR (LOG2_FACTOR),
        .MAX_DELAY   (MAX_DELAY),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tas_fail),
        .attempt (losses),
        .done    (timer_done)
    );

    assign mem_req_valid = cmd.valid;
    assign mem_req_op    = cmd.op;
    assign mem_req_addr  = lock_addr;
    assign mem_req_wdata = '0;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        idle |-> !mem_req_valid)
        else $error("request while idle");

    p_tas_after_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_op == MOP_TAS && !$past(mem_req_valid && mem_req_op == MOP_TAS))
        |-> $past(mem_rsp_valid && mem_rsp_data == '0))
        else $error("test-and-set without a zero read");

    p_win_grants_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(granted) |-> $past(mem_rsp_valid && mem_rsp_data == '0))
        else $error("grant without a zero response");

    p_loss_no_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && mem_rsp_data != '0) |=> !granted)
        else $error("grant after a nonzero response");

    p_release_store_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(granted) |-> (mem_req_valid && mem_req_op == MOP_STORE))
        else $error("release without store");

    p_req_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_op)))
        else $error("request dropped before acceptance");

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(granted && idle))
        else $error("granted and idle together");

endmodule

// File: tb/tts_lock_engine_tb.sv
`timescale 1ns/1ps
module tts_lock_engine_tb;
    import spinlock_pkg::*;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acq_req = 1'b0, rel_req = 1'b0;
    logic [ADDR_W-1:0] lock_addr = 32'h0000_1F40;
    logic              granted, idle;
    logic              mem_req_valid, mem_req_ready = 1'b1;
    logic [1:0]        mem_req_op;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    tts_lock_engine u_dut (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
        .lock_addr(lock_addr), .granted(granted), .idle(idle),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint actual, input longint expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DATA_W-1:0] word = '0;
    int                steals = 0;
    bit                bp_mode = 1'b0;
    int                cyc = 0;

    always @(posedge clk) begin
        mem_req_ready <= !bp_mode || cyc[0];
        if (rst) begin
            mem_rsp_valid <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                case (mem_req_op)
                    MOP_READ: begin
                        mem_rsp_valid <= 1'b1;
                        mem_rsp_data  <= word;
                    end
                    MOP_TAS: begin
                        mem_rsp_valid <= 1'b1;
                        if (steals > 0) begin
                            mem_rsp_data <= 1;
                            steals <= steals - 1;
                        end else begin
                            mem_rsp_data <= word;
                            word <= 1;
                        end
                    end
                    MOP_STORE: word <= mem_req_wdata;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [1:0] op;
        int         gap;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    task automatic expect_op(input logic [1:0] op, input int gap, input string req);
        exp_t e;
        e.op = op; e.gap = gap; e.req = req;
        exp_q.push_back(e);
    endtask

    int  last_acc = 0;
    bit  prev_stall = 1'b0;
    logic [1:0] prev_op = '0;
    bit  excl_bad = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (granted && idle) excl_bad = 1'b1;
            if (prev_stall)
                check(mem_req_valid && mem_req_op == prev_op, "R9", "held request",
                      {mem_req_valid, mem_req_op}, {1'b1, prev_op});
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_op    = mem_req_op;
            if (mem_req_valid && mem_req_ready) begin
                check(mem_req_addr == lock_addr, "R2", "request address", mem_req_addr, lock_addr);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected request op", mem_req_op, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mem_req_op == e.op, e.req, "request op", mem_req_op, e.op);
                    if (e.gap >= 0)
                        check(cyc - last_acc == e.gap, e.req, "request spacing", cyc - last_acc, e.gap);
                    if (e.op == MOP_STORE)
                        check(mem_req_wdata == '0, "R8", "store data", mem_req_wdata, 0);
                end
                last_acc = cyc;
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    task automatic pulse_acq();
        @(negedge clk) acq_req = 1'b1;
        @(negedge clk) acq_req = 1'b0;
    endtask

    task automatic do_release(input string req);
        expect_op(MOP_STORE, -1, "R8");
        @(negedge clk) rel_req = 1'b1;
        @(negedge clk) rel_req = 1'b0;
        check(granted == 1'b0, "R8", "granted after release", granted, 0);
        drain();
        repeat (2) @(negedge clk);
        check(idle == 1'b1, req, "idle after release", idle, 1);
        check(word == '0, "R8", "lock word after release", word, 0);
    endtask

    task automatic expect_granted(input string req);
        drain();
        repeat (3) @(negedge clk);
        check(granted == 1'b1, req, "granted", granted, 1);
        check(idle == 1'b0, "R10", "idle while granted", idle, 0);
    endtask

    task automatic scenario();
        int d;
        repeat (3) @(negedge clk);
        check(idle == 1'b1, "R1", "idle in reset", idle, 1);
        check(granted == 1'b0, "R1", "granted in reset", granted, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(mem_req_valid == 1'b0, "R1", "request after reset", mem_req_valid, 0);

        // free lock
        expect_op(MOP_READ, -1, "R2");
        expect_op(MOP_TAS, 2, "R3");
        pulse_acq();
        check(idle == 1'b0, "R10", "idle during acquire", idle, 0);
        expect_granted("R4");
        check(word == 1, "R4", "lock word after win", word, 1);
        do_release("R8");

        // held lock: polling only
        word = 1;
        expect_op(MOP_READ, -1, "R2");
        for (int i = 0; i < 4; i++) expect_op(MOP_READ, 2, "R2");
        pulse_acq();
        drain();
        @(negedge clk);
        expect_op(MOP_READ, 2, "R2");
        expect_op(MOP_TAS, 2, "R3");
        word = 0;
        expect_granted("R4");
        do_release("R8");

        // six lost races: doubling then cap
        steals = 6;
        expect_op(MOP_READ, -1, "R2");
        expect_op(MOP_TAS, 2, "R3");
        d = 4;
        for (int n = 1; n <= 6; n++) begin
            expect_op(MOP_READ, (d > 64 ? 64 : d) + 2, (d > 64) ? "R6" : "R5");
            expect_op(MOP_TAS, 2, "R3");
            d = d * 2;
        end
        pulse_acq();
        expect_granted("R4");
        do_release("R8");

        // loss count restarts after a win
        steals = 1;
        expect_op(MOP_READ, -1, "R2");
        expect_op(MOP_TAS, 2, "R3");
        expect_op(MOP_READ, 6, "R7");
        expect_op(MOP_TAS, 2, "R7");
        pulse_acq();
        expect_granted("R7");
        do_release("R8");

        // back-pressure on the request channel
        bp_mode = 1'b1;
        steals = 1;
        expect_op(MOP_READ, -1, "R9");
        expect_op(MOP_TAS, -1, "R9");
        expect_op(MOP_READ, -1, "R9");
        expect_op(MOP_TAS, -1, "R9");
        pulse_acq();
        expect_granted("R9");
        do_release("R9");
        bp_mode = 1'b0;

        repeat (4) @(negedge clk);
        check(!excl_bad, "R10", "granted and idle together seen", excl_bad, 0);
        check(exp_q.size() == 0, "R2", "leftover expected requests", exp_q.size(), 0);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "R1", "watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule